// File: doc/BRIEF.md
# Snoop-Aware Address Bus Arbiter

This block decides which of the processors on a shared, pipelined, split-transaction bus may drive the next address tenure. Each processor raises a request line. The block answers with one-hot grant lines. It watches three bus-wide signals: the tenure start strobe, the address acknowledge that ends a tenure, and the address retry line that snoopers assert in the cycle after an acknowledge. When no one else requests, the grant stays parked on the last owner, so that owner can issue back-to-back tenures without arbitrating again. Outside retry handling, the lowest-numbered requester wins.

When a snooper retries a tenure, the arbiter drops every grant for one cycle. This opens a window in which the snooping processor can ask for the bus to push its modified line. A request seen in that window becomes a pending push. The push master is granted as soon as no tenure is open. The retried master cannot win the bus again until the push tenure has been acknowledged. This holds even when the acknowledge of a pipelined second tenure is delayed past the window. That second tenure is treated as cancelled: a retry asserted in its own retry cycle is ignored.

Top module: `addr_bus_arbiter`

## Requirements
- R1: Reset drives the grant to processor 0 only (bus_gnt = 2'b01), closes any tenure and discards a pending push, so processor 0 keeps the bus after reset even when both processors request.
- R2: At most one bit of bus_gnt is high in any cycle.
- R3: With no requests and no tenure open, the grant stays on the last owner. The grant also stays on an owner that still requests. It moves to another requester only when the owner has dropped its request.
- R4: A tenure opens on the cycle tenure_start is sampled and closes on the cycle addr_ack is sampled. While a tenure is open and addr_ack is low, the grant is never handed to a different processor.
- R5: addr_retry sampled high in the cycle directly after an addr_ack counts as a retry of that tenure's master, and bus_gnt is all zero in the following cycle. addr_retry in any other cycle has no effect on bus_gnt.
- R6: A request from a processor other than the retried one, sampled in the all-zero grant cycle, is recorded as a push. The push master is granted in the next cycle if no tenure is open, otherwise right after the open tenure's addr_ack.
- R7: While a push is pending, the retried master is never granted, including while a pipelined tenure's addr_ack arrives late.
- R8: A push ends when addr_ack closes the push master's tenure. Normal arbitration applies from that same edge, so a waiting retried master holds the grant in the next cycle.
- R9: A tenure started in the same cycle as, or open at, a detected retry is cancelled. addr_retry in its retry cycle is ignored, as is addr_retry while a push is pending.
- R10: When the grant is free (all zero, no tenure open) and several processors request, the lowest-numbered one wins.
- R11: If no request is recorded during the all-zero grant cycle, ordinary arbitration resumes with no ordering constraint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | N_MST | Per-processor address bus request, active high |
| tenure_start | input | 1 | Start of an address tenure by the granted master |
| addr_ack | input | 1 | Address acknowledge; ends the open tenure |
| addr_retry | input | 1 | Snoop retry, meaningful in the cycle after addr_ack |
| bus_gnt | output | N_MST | One-hot address bus grant |

## Verification
The hardest overlap is a retry that arrives in the same cycle as the retried master's next tenure_start. That one cycle ends the first tenure's retry handling and opens a tenure that must be cancelled. The bench provokes this by pipelining a second tenure behind the first and asserting addr_retry together with its start. It then holds addr_ack back past the all-zero window. The scoreboard expects the push master to be granted exactly at the delayed acknowledge, the retried master to stay off the bus while it requests, and a retry pulse in the cancelled tenure's retry cycle to leave the grant unchanged. A second overlap ends the push in the same cycle that the retried master is requesting. There the expected grant hand-over is checked on the very next cycle.

// File: rtl/abarb_pkg.sv
package abarb_pkg;

  // How the grant unit forms its next grant vector.
  typedef enum logic [1:0] {
    SEL_NORMAL = 2'd0,
    SEL_RETRY  = 2'd1,
    SEL_PUSH   = 2'd2
  } sel_mode_e;

  localparam int unsigned DEF_MASTERS = 2;

endpackage

// File: rtl/abarb_tenure.sv
module abarb_tenure #(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack,
  input  logic [N-1:0]  gnt,
  input  logic          retry_hit,
  output logic          busy,
  output logic [IW-1:0] cur_owner,
  output logic          win_valid,
  output logic [IW-1:0] win_owner
);

  logic          busy_q, busy_d;
  logic [IW-1:0] own_q, own_d;
  logic          ackd_q, ackd_d;
  logic [IW-1:0] wown_q, wown_d;
  logic          cancel_q, cancel_d;
  logic          ign_q, ign_d;
  logic [IW-1:0] gidx;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) gidx = IW'(i);
    end
  end

  always_comb begin
    busy_d   = busy_q;
    own_d    = own_q;
    cancel_d = cancel_q;
    if (start) begin
      busy_d = 1'b1;
      own_d  = gidx;
    end else if (ack) begin
      busy_d = 1'b0;
    end
    ackd_d = ack && busy_q;
    wown_d = own_q;
    ign_d  = ack && busy_q && cancel_q;
    if (ack && busy_q) cancel_d = 1'b0;
    if (retry_hit && (start || busy_q)) cancel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      own_q    <= '0;
      ackd_q   <= 1'b0;
      wown_q   <= '0;
      cancel_q <= 1'b0;
      ign_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      own_q    <= own_d;
      ackd_q   <= ackd_d;
      wown_q   <= wown_d;
      cancel_q <= cancel_d;
      ign_q    <= ign_d;
    end
  end

  assign busy      = busy_q;
  assign cur_owner = own_q;
  assign win_valid = ackd_q && !ign_q;
  assign win_owner = wown_q;

  // R4: a sampled start leaves a tenure open in the next cycle
  a_r4_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  // R5: a retry window only follows a cycle in which an open tenure was acknowledged
  a_r5_window_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(ack));

endmodule

// File: rtl/abarb_retry.sv
module abarb_retry #(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          artry_in,
  input  logic          ack,
  input  logic          busy,
  input  logic [IW-1:0] cur_owner,
  input  logic          win_valid,
  input  logic [IW-1:0] win_owner,
  output logic          retry_hit,
  output logic          window,
  output logic          push_go,
  output logic [IW-1:0] push_tgt,
  output logic          push_pend,
  output logic [IW-1:0] retried
);

  logic          window_q, window_d;
  logic          pend_q, pend_d;
  logic [IW-1:0] pm_q, pm_d;
  logic [IW-1:0] rt_q, rt_d;
  logic          hit;
  logic [IW-1:0] hidx;
  logic          push_done;

  // lowest-numbered requester other than the retried master
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i] && (IW'(i) != rt_q)) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
    end
  end

  always_comb begin
    retry_hit = win_valid && artry_in && !window_q && !pend_q;
    push_done = pend_q && ack && busy && (cur_owner == pm_q);
    push_go   = (window_q && hit) || (pend_q && !push_done);
    push_tgt  = window_q ? hidx : pm_q;
  end

  always_comb begin
    window_d = retry_hit;
    rt_d     = retry_hit ? win_owner : rt_q;
    pend_d   = pend_q;
    pm_d     = pm_q;
    if (push_done) pend_d = 1'b0;
    if (window_q && hit) begin
      pend_d = 1'b1;
      pm_d   = hidx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_q <= 1'b0;
      pend_q   <= 1'b0;
      pm_q     <= '0;
      rt_q     <= '0;
    end else begin
      window_q <= window_d;
      pend_q   <= pend_d;
      pm_q     <= pm_d;
      rt_q     <= rt_d;
    end
  end

  assign window    = window_q;
  assign push_pend = pend_q;
  assign retried   = rt_q;

  // R5: the request window lasts exactly one cycle
  a_r5_window_single: assert property (@(posedge clk) disable iff (!rst_n)
    window_q |=> !window_q);

  // R9: no new retry is recognised while a push is outstanding
  a_r9_no_retry_in_push: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !retry_hit);

endmodule

// File: rtl/abarb_grant.sv
module abarb_grant
  import abarb_pkg::*;
#(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ack,
  input  logic          busy,
  input  logic          retry_hit,
  input  logic          push_go,
  input  logic [IW-1:0] push_tgt,
  output logic [N-1:0]  gnt
);

  logic [N-1:0]  gnt_q, gnt_d;
  logic [IW-1:0] park_q, park_d;
  logic [N-1:0]  tgt_oh, pick_oh, park_oh;
  logic          free;
  sel_mode_e     mode;

  always_comb begin
    tgt_oh  = '0;
    park_oh = '0;
    for (int i = 0; i < N; i++) begin
      tgt_oh[i]  = (IW'(i) == push_tgt);
      park_oh[i] = (IW'(i) == park_q);
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    pick_oh = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        pick_oh    = '0;
        pick_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    free = !busy || ack;
    if (retry_hit)    mode = SEL_RETRY;
    else if (push_go) mode = SEL_PUSH;
    else              mode = SEL_NORMAL;
  end

  always_comb begin
    gnt_d = gnt_q;
    unique case (mode)
      SEL_RETRY: gnt_d = '0;
      SEL_PUSH:  gnt_d = (free || (gnt_q == tgt_oh)) ? tgt_oh : '0;
      default: begin
        if (!free)               gnt_d = gnt_q;
        else if (|(gnt_q & req)) gnt_d = gnt_q;
        else if (|req)           gnt_d = pick_oh;
        else                     gnt_d = park_oh;
      end
    endcase
  end

  always_comb begin
    park_d = park_q;
    for (int i = 0; i < N; i++) begin
      if (gnt_d[i]) park_d = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= {{(N-1){1'b0}}, 1'b1};
      park_q <= '0;
    end else begin
      gnt_q  <= gnt_d;
      park_q <= park_d;
    end
  end

  assign gnt = gnt_q;

  // R2: never more than one grant
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R4: an open, unacknowledged tenure keeps the grant or leaves it empty
  a_r4_no_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |=> ((gnt_q == $past(gnt_q)) || (gnt_q == '0)));

endmodule

// File: rtl/addr_bus_arbiter.sv
module addr_bus_arbiter #(
  parameter int unsigned N_MST = abarb_pkg::DEF_MASTERS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] bus_req,
  input  logic             tenure_start,
  input  logic             addr_ack,
  input  logic             addr_retry,
  output logic [N_MST-1:0] bus_gnt
);

  localparam int unsigned IW = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic          busy;
  logic [IW-1:0] cur_owner;
  logic          win_valid;
  logic [IW-1:0] win_owner;
  logic          retry_hit;
  logic          window;
  logic          push_go;
  logic [IW-1:0] push_tgt;
  logic          push_pend;
  logic [IW-1:0] retried;

  abarb_tenure #(.N(N_MST), .IW(IW)) u_tenure (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (tenure_start),
    .ack       (addr_ack),
    .gnt       (bus_gnt),
    .retry_hit (retry_hit),
    .busy      (busy),
    .cur_owner (cur_owner),
    .win_valid (win_valid),
    .win_owner (win_owner)
  );

  abarb_retry #(.N(N_MST), .IW(IW)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req),
    .artry_in  (addr_retry),
    .ack       (addr_ack),
    .busy      (busy),
    .cur_owner (cur_owner),
    .win_valid (win_valid),
    .win_owner (win_owner),
    .retry_hit (retry_hit),
    .window    (window),
    .push_go   (push_go),
    .push_tgt  (push_tgt),
    .push_pend (push_pend),
    .retried   (retried)
  );

  abarb_grant #(.N(N_MST), .IW(IW)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req),
    .ack       (addr_ack),
    .busy      (busy),
    .retry_hit (retry_hit),
    .push_go   (push_go),
    .push_tgt  (push_tgt),
    .gnt       (bus_gnt)
  );

  // R7: a pending push keeps the retried master off the bus
  a_r7_retried_held: assert property (@(posedge clk) disable iff (!rst_n)
    push_pend |-> !bus_gnt[retried]);

  // R5: a recognised retry empties the grant on the next cycle
  a_r5_grant_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    retry_hit |=> (bus_gnt == '0));

  // R5: the all-zero window never carries a grant
  a_r5_window_empty: assert property (@(posedge clk) disable iff (!rst_n)
    window |-> (bus_gnt == '0));

  // R3: an idle bus keeps its parked grant
  a_r3_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (bus_req == '0) && (bus_gnt != '0) && !retry_hit && !push_go)
      |=> $stable(bus_gnt));

endmodule

// File: tb/addr_bus_arbiter_tb_top.sv
module addr_bus_arbiter_tb_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] req;
  logic       ts;
  logic       ack;
  logic       rty;
  logic [1:0] gnt;

  int n_chk;
  int n_fail;
  int cyc;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  addr_bus_arbiter #(.N_MST(2)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (req),
    .tenure_start (ts),
    .addr_ack     (ack),
    .addr_retry   (rty),
    .bus_gnt      (gnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: bus_gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of inputs and queues the grant expected after that edge
  task automatic step(input logic [1:0] r, input logic t, input logic a,
                      input logic x, input logic [1:0] e, input string tag);
    @(negedge clk);
    req = r; ts = t; ack = a; rty = x;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares the grant just after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      check(gnt, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    req = 2'b00; ts = 1'b0; ack = 1'b0; rty = 1'b0;
    rst_n = 1'b0;
    #1;
    check(gnt, 2'b01, tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0;
    req = 2'b00; ts = 1'b0; ack = 1'b0; rty = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(gnt, 2'b01, "R1 reset grant");
    @(negedge clk);
    rst_n = 1'b1;

    // parking and moving
    step(2'b00, 0, 0, 0, 2'b01, "R3 park on P0");
    step(2'b10, 0, 0, 0, 2'b10, "R3 move to idle-owner rival");
    step(2'b00, 0, 0, 0, 2'b10, "R3 park on P1");
    step(2'b11, 0, 0, 0, 2'b10, "R3 owner keeps grant");
    step(2'b01, 0, 0, 0, 2'b01, "R3 owner dropped");

    // tenure hold, stray retry
    step(2'b01, 1, 0, 0, 2'b01, "R4 tenure opens");
    step(2'b10, 0, 0, 0, 2'b01, "R4 no handover while open");
    step(2'b10, 0, 1, 0, 2'b10, "R4 handover at ack");
    step(2'b10, 0, 0, 0, 2'b10, "R4 quiet retry cycle");
    step(2'b10, 0, 0, 1, 2'b10, "R5 stray retry ignored");

    // cancelled pipelined tenure, empty window, priority
    step(2'b10, 1, 0, 0, 2'b10, "R4 P1 tenure");
    step(2'b10, 0, 1, 0, 2'b10, "R4 P1 ack");
    step(2'b10, 1, 0, 1, 2'b00, "R5 retry with pipelined start");
    step(2'b00, 0, 0, 0, 2'b00, "R11 empty window, tenure open");
    step(2'b11, 0, 0, 0, 2'b00, "R4 cancelled tenure still open");
    step(2'b11, 0, 1, 0, 2'b01, "R10 P0 wins free bus");
    step(2'b01, 0, 0, 1, 2'b01, "R9 retry of cancelled tenure ignored");

    // delayed acknowledge with push
    step(2'b01, 0, 0, 0, 2'b01, "R3 P0 holds");
    step(2'b01, 1, 0, 0, 2'b01, "R4 first tenure");
    step(2'b01, 0, 1, 0, 2'b01, "R3 parked for second");
    step(2'b01, 1, 0, 1, 2'b00, "R5 retry overlaps second start");
    step(2'b10, 0, 0, 0, 2'b00, "R6 push recorded, tenure open");
    step(2'b11, 0, 1, 0, 2'b10, "R7 push ahead of retried master");
    step(2'b10, 0, 0, 1, 2'b10, "R9 retry in cancelled window ignored");
    step(2'b11, 1, 0, 0, 2'b10, "R7 push tenure, P0 waits");
    step(2'b01, 0, 1, 0, 2'b01, "R8 retried master after push ack");
    step(2'b01, 0, 0, 0, 2'b01, "R8 retried master holds");
    step(2'b01, 1, 0, 0, 2'b01, "R8 retried tenure");
    step(2'b00, 0, 1, 0, 2'b01, "R3 after retried ack");
    step(2'b00, 0, 0, 0, 2'b01, "R3 idle parked");

    // push with no delayed acknowledge
    step(2'b01, 1, 0, 0, 2'b01, "R4 tenure");
    step(2'b01, 0, 1, 0, 2'b01, "R4 ack");
    step(2'b01, 0, 0, 1, 2'b00, "R5 retry drops grant");
    step(2'b11, 0, 0, 0, 2'b10, "R6 push granted at once");
    step(2'b11, 0, 0, 0, 2'b10, "R7 retried master waits");
    step(2'b11, 1, 0, 0, 2'b10, "R7 push tenure open");
    step(2'b01, 0, 1, 0, 2'b01, "R8 hand back at push ack");
    step(2'b00, 0, 0, 0, 2'b01, "R3 parked");

    // reset clears a pending push
    step(2'b01, 1, 0, 0, 2'b01, "R4 tenure before reset");
    step(2'b01, 0, 1, 0, 2'b01, "R4 ack before reset");
    step(2'b01, 0, 0, 1, 2'b00, "R5 retry before reset");
    step(2'b10, 0, 0, 0, 2'b10, "R6 push before reset");
    @(posedge clk);
    #3;
    do_reset("R1 mid-run reset grant");
    step(2'b11, 0, 0, 0, 2'b01, "R1 push cleared by reset");
    step(2'b00, 0, 0, 0, 2'b01, "R1 parked after reset");

    @(posedge clk);
    #3;
    finish_run();
  end

endmodule